// File: doc/BRIEF.md
# Character Panel Scan Generator

This block drives the row-multiplexed scan of a character display with 33 common lines and 120 segment columns. It walks through the commons at a fixed number of clocks per line. For every line it fetches character codes from the display RAM through a read port and the matching 5-dot glyph row through a font lookup port. It then applies the display shift, the cursor inversion and the blink, and assembles a 120-bit segment row. The finished row is handed to a parallel output latch when the next line period begins.

Common index 0 is the icon line. For that line the row is filled from the sixteen glyph-RAM bytes at 0x30..0x3F instead of from characters. The row layout follows the line mode. In two-line mode each 48-character line is split across two 8-common groups. In four-line mode each 24-character line has its own group. Shifted lines rotate inside their own address range.

Top module: `lcd_scan_engine`

## Requirements
- R1: Each line period lasts CLKS_PER_LINE clocks. At the start of each period `seg_load` pulses for one cycle, `com_sel` advances 0,1,...,32,0 and `seg_latch` takes the row built during the period before. `frame_strobe` pulses exactly with the load of common 0.
- R2: Common 0 shows icons. Glyph-RAM byte 0x30+j (j=0..15) supplies its low 5 bits: bit 4 goes to segment index 75-5j and bit 0 to index 79-5j, where `seg_latch` bit 0 is the leftmost segment. Segment indices 80..119 are 0 on this line.
- R3: On common n (1..32) the character in cell k (0..23) occupies `seg_latch[5k+4:5k]`. Font bit 4 goes to index 5k and font bit 0 to index 5k+4. The font row requested is (n-1) mod 8. `dd_data` is valid one cycle after `dd_addr`. `font_data` is valid one cycle after a `font_req` cycle that carries `font_code`/`font_row`. `icon_data` is valid one cycle after `icon_addr`.
- R4: With `four_line`=0, commons 1-8, 9-16, 17-24 and 25-32 show display-RAM positions 0..23, 24..47, 0..23 and 24..47 of the lines based at 0x00, 0x00, 0x40 and 0x40.
- R5: With `four_line`=1, commons 1-8, 9-16, 17-24 and 25-32 show 24 characters from bases 0x00, 0x20, 0x40 and 0x60.
- R6: A shift offset s (`shift_ofs`, 0..47) makes position p read line address base+((p+s) mod L), where L is 48 in two-line mode and 24 in four-line mode.
- R7: With `cursor_on`=1, the cell whose display-RAM address equals `cursor_addr` shows its glyph row bit-inverted on every common of its group.
- R8: A blink phase starts at 0 after reset and toggles on every BLINK_FRAMES-th frame start, so after n frame starts it is floor(n/BLINK_FRAMES) mod 2. While `blink_on`=1 and the phase is 1, the cursor cell shows all dots on. This takes priority over inversion.
- R9: A row loaded while `disp_on`=0 is all zero, on the icon line too. Re-enabling brings back the stored content.
- R10: During and right after reset, `seg_latch` is 0, `com_sel` is 32, and `seg_load` and `frame_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Cursor inversion enable |
| blink_on | input | 1 | Cursor blink enable |
| four_line | input | 1 | 1: four lines of 24, 0: two lines of 48 |
| shift_ofs | input | 6 | Display shift offset, 0..47 |
| cursor_addr | input | 7 | Display-RAM address of the cursor |
| dd_addr | output | 7 | Display-RAM read address |
| dd_data | input | 8 | Character code, one cycle after address |
| font_req | output | 1 | Glyph row request |
| font_code | output | 8 | Character code of the request |
| font_row | output | 3 | Glyph row of the request |
| font_data | input | DOTS | Glyph row dots, one cycle after request |
| icon_addr | output | 6 | Glyph-RAM address for icon bytes |
| icon_data | input | DOTS | Low bits of the icon byte, one cycle after address |
| com_sel | output | IW | Common index whose row is in the latch |
| seg_latch | output | SEGS | Segment row driven to the panel |
| seg_load | output | 1 | Latch update and line strobe |
| frame_strobe | output | 1 | Pulse at the load of common 0 |

## Verification
The bench builds the block with CLKS_PER_LINE=32 and BLINK_FRAMES=2. A frame is then 1056 clocks, and a few consecutive frames cover both blink phases. Thirty-two clocks still leave room for 24 character fetches through the two-stage read pipeline. Several whole frames can be compared row by row in every mode, shift value and cursor setting.

// File: rtl/lcd_scan_engine.sv
module lcd_scan_engine #(
  parameter int CLKS_PER_LINE = 120,
  parameter int COMMONS       = 33,
  parameter int SEGS          = 120,
  parameter int DOTS          = 5,
  parameter int BLINK_FRAMES  = 25,
  localparam int IW           = $clog2(COMMONS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_on,
  input  logic            cursor_on,
  input  logic            blink_on,
  input  logic            four_line,
  input  logic [5:0]      shift_ofs,
  input  logic [6:0]      cursor_addr,
  output logic [6:0]      dd_addr,
  input  logic [7:0]      dd_data,
  output logic            font_req,
  output logic [7:0]      font_code,
  output logic [2:0]      font_row,
  input  logic [DOTS-1:0] font_data,
  output logic [5:0]      icon_addr,
  input  logic [DOTS-1:0] icon_data,
  output logic [IW-1:0]   com_sel,
  output logic [SEGS-1:0] seg_latch,
  output logic            seg_load,
  output logic            frame_strobe
);
  localparam int CHARS = SEGS / DOTS;
  localparam int ICONS = 16;
  localparam int CW    = $clog2(CLKS_PER_LINE);
  localparam int KW    = $clog2(CHARS);
  localparam int BW    = $clog2(BLINK_FRAMES) + 1;

  function automatic logic [DOTS-1:0] mirror(input logic [DOTS-1:0] x);
    for (int i = 0; i < DOTS; i++) mirror[i] = x[DOTS-1-i];
  endfunction

  logic [CW-1:0]   cyc;
  logic [IW-1:0]   bidx;
  logic [SEGS-1:0] row_buf;
  logic [BW-1:0]   fcnt;
  logic            phase;
  logic            s1_v, s1_hit, s2_v, s2_hit, i1_v;
  logic [KW-1:0]   s1_k, s2_k;
  logic [3:0]      i1_m;

  wire wrap     = (cyc == CW'(CLKS_PER_LINE - 1));
  wire fetch_ch = (bidx != '0) && (int'(cyc) < CHARS);
  wire fetch_ic = (bidx == '0) && (int'(cyc) < ICONS);

  wire [4:0] nm1 = 5'(bidx - IW'(1));
  wire [1:0] grp = nm1[4:3];
  wire [6:0] k7  = 7'(cyc);
  wire [6:0] ofs = {1'b0, shift_ofs};

  wire [6:0] p2  = (grp[0] ? 7'd24 : 7'd0) + k7 + ofs;
  wire [6:0] p2w = (p2 >= 7'd48) ? p2 - 7'd48 : p2;
  wire [6:0] a2  = {grp[1], 6'b0} + p2w;

  wire [6:0] p4  = k7 + ofs;
  wire [6:0] p4a = (p4 >= 7'd48) ? p4 - 7'd48 : p4;
  wire [6:0] p4b = (p4a >= 7'd24) ? p4a - 7'd24 : p4a;
  wire [6:0] a4  = {grp, 5'b0} + p4b;

  assign dd_addr   = four_line ? a4 : a2;
  assign icon_addr = 6'h3F - 6'(cyc);
  assign font_req  = s1_v;
  assign font_code = dd_data;
  assign font_row  = nm1[2:0];

  wire [DOTS-1:0] pat = (blink_on && phase && s2_hit) ? '1 :
                        (cursor_on && s2_hit) ? ~font_data : font_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0; bidx <= '0; row_buf <= '0; seg_latch <= '0;
      com_sel <= IW'(COMMONS - 1); seg_load <= 1'b0; frame_strobe <= 1'b0;
      fcnt <= '0; phase <= 1'b0;
      s1_v <= 1'b0; s1_hit <= 1'b0; s1_k <= '0;
      s2_v <= 1'b0; s2_hit <= 1'b0; s2_k <= '0;
      i1_v <= 1'b0; i1_m <= '0;
    end else begin
      cyc          <= wrap ? '0 : cyc + CW'(1);
      s1_v         <= fetch_ch;
      s1_k         <= KW'(cyc);
      s1_hit       <= (dd_addr == cursor_addr);
      s2_v         <= s1_v;
      s2_k         <= s1_k;
      s2_hit       <= s1_hit;
      i1_v         <= fetch_ic;
      i1_m         <= 4'(cyc);
      seg_load     <= wrap;
      frame_strobe <= wrap && (bidx == '0);
      if (wrap) begin
        row_buf   <= '0;
        seg_latch <= disp_on ? row_buf : '0;
        com_sel   <= bidx;
        bidx      <= (bidx == IW'(COMMONS - 1)) ? '0 : bidx + IW'(1);
        if (bidx == '0) begin
          if (fcnt == BW'(BLINK_FRAMES - 1)) begin
            fcnt  <= '0;
            phase <= ~phase;
          end else begin
            fcnt <= fcnt + BW'(1);
          end
        end
      end else begin
        if (s2_v) row_buf[int'(s2_k)*DOTS +: DOTS] <= mirror(pat);
        if (i1_v) row_buf[int'(i1_m)*DOTS +: DOTS] <= mirror(icon_data);
      end
    end
  end

  a_r1_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |=> !seg_load);

  a_r1_com_order: assert property (@(posedge clk) disable iff (!rst_n)
    seg_load |-> com_sel == (($past(com_sel) == IW'(COMMONS - 1)) ? '0 : $past(com_sel) + IW'(1)));

  a_r1_frame_on_icon: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (seg_load && com_sel == '0));

  a_r2_icon_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_load && com_sel == '0) |-> seg_latch[SEGS-1:ICONS*DOTS] == '0);

  a_r9_blank_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_load && !$past(disp_on)) |-> seg_latch == '0);

  a_r3_no_font_on_icon: assert property (@(posedge clk) disable iff (!rst_n)
    (bidx == '0 && int'(cyc) > 1 && int'(cyc) < CHARS) |-> !font_req);
endmodule

// File: tb/lcd_scan_engine_test.sv
module lcd_scan_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int LPL = 32;
  localparam int BF  = 2;

  logic clk = 0, rst_n = 0;
  logic disp_on = 1, cursor_on = 0, blink_on = 0, four_line = 0;
  logic [5:0] shift_ofs = 0;
  logic [6:0] cursor_addr = 0;
  logic [6:0] dd_addr; logic [7:0] dd_data = 0;
  logic font_req; logic [7:0] font_code; logic [2:0] font_row; logic [4:0] font_data = 0;
  logic [5:0] icon_addr; logic [4:0] icon_data = 0;
  logic [5:0] com_sel; logic [119:0] seg_latch; logic seg_load, frame_strobe;

  lcd_scan_engine #(.CLKS_PER_LINE(LPL), .BLINK_FRAMES(BF)) uut (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .four_line(four_line), .shift_ofs(shift_ofs), .cursor_addr(cursor_addr),
    .dd_addr(dd_addr), .dd_data(dd_data), .font_req(font_req), .font_code(font_code),
    .font_row(font_row), .font_data(font_data), .icon_addr(icon_addr), .icon_data(icon_data),
    .com_sel(com_sel), .seg_latch(seg_latch), .seg_load(seg_load), .frame_strobe(frame_strobe));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] ddm [128];
  logic [7:0] icm [64];
  int tests = 0, fails = 0, strobes_seen = 0, gap = 0;
  bit have_prev = 0;

  typedef struct packed { logic [5:0] com; logic [119:0] row; } item_t;
  item_t q[$];
  string tag_q[$];

  function automatic logic [4:0] fnt(input logic [7:0] c, input logic [2:0] r);
    logic [7:0] t;
    t = (c ^ (c >> 3)) + 8'(r) * 8'd5;
    return t[4:0];
  endfunction

  always @(posedge clk) begin
    dd_data   <= ddm[dd_addr];
    icon_data <= icm[icon_addr][4:0];
    if (font_req) font_data <= fnt(font_code, font_row);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [119:0] exp_row(input int n, input bit ph);
    logic [119:0] v = '0;
    if (!disp_on) return v;
    if (n == 0) begin
      for (int a = 0; a < 16; a++)
        for (int t = 0; t < 5; t++) v[75 - 5*a + t] = icm[48 + a][4 - t];
    end else begin
      int g, r, addr;
      logic [4:0] pat;
      g = (n - 1) / 8; r = (n - 1) % 8;
      for (int k = 0; k < 24; k++) begin
        if (four_line) addr = g*32 + (k + int'(shift_ofs)) % 24;
        else addr = (g/2)*64 + ((g%2)*24 + k + int'(shift_ofs)) % 48;
        pat = fnt(ddm[addr], 3'(r));
        if (blink_on && ph && addr == int'(cursor_addr)) pat = '1;
        else if (cursor_on && addr == int'(cursor_addr)) pat = ~pat;
        for (int t = 0; t < 5; t++) v[5*k + t] = pat[4 - t];
      end
    end
    return v;
  endfunction

  // Monitor: timing checks (R1) and scoreboard pops
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_strobe && !seg_load) chk(0, "R1", "frame_strobe without load", 1, 0);
      if (seg_load) begin
        if (have_prev) chk(gap == LPL, "R1", "line period", gap, LPL);
        have_prev = 1; gap = 1;
        chk(frame_strobe == (com_sel == 0), "R1", "frame strobe at common 0", frame_strobe, com_sel == 0);
        if (frame_strobe) strobes_seen++;
        if (q.size() > 0) begin
          item_t it; string tg;
          it = q.pop_front(); tg = tag_q.pop_front();
          chk(com_sel == it.com, tg, "common index", com_sel, it.com);
          chk(seg_latch == it.row, tg, $sformatf("row com %0d", it.com), seg_latch, it.row);
        end
      end else gap++;
    end
  end

  task automatic wait_strobe();
    do begin @(posedge clk); #1; end while (!frame_strobe);
  endtask

  task automatic push(input int n, input bit ph, input string tg);
    item_t it;
    it.com = 6'(n); it.row = exp_row(n, ph);
    q.push_back(it); tag_q.push_back(tg);
  endtask

  // Driver: flush one frame, then predict nf whole frames
  task automatic run_frames(input int nf, input string tg);
    int n0;
    wait_strobe();
    wait_strobe();
    n0 = strobes_seen + 1;
    push(0, 0, tg);
    for (int f = 0; f < nf; f++) begin
      bit ph;
      ph = ((n0 + f) / BF) % 2;
      for (int c = 1; c <= 32; c++) push(c, ph, tg);
      push(0, ph, tg);
    end
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) ddm[i] = 8'((i * 7 + 3) ^ (i >> 2));
    for (int i = 0; i < 64; i++) icm[i] = 8'(i * 11 + 8'hE5);
    repeat (4) @(negedge clk);
    chk(seg_latch == 0, "R10", "latch in reset", seg_latch, 0);
    chk(com_sel == 32, "R10", "com_sel in reset", com_sel, 32);
    chk(!seg_load && !frame_strobe, "R10", "strobes in reset", {seg_load, frame_strobe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(seg_latch == 0 && com_sel == 32, "R10", "state after release", {com_sel, seg_latch}, {6'd32, 120'd0});

    run_frames(1, "R2 R3 R4 two-line");
    four_line = 1;
    run_frames(1, "R5 four-line");
    four_line = 0; shift_ofs = 5;
    run_frames(1, "R6 two-line shift 5");
    shift_ofs = 47;
    run_frames(1, "R6 two-line shift 47");
    four_line = 1; shift_ofs = 30;
    run_frames(1, "R6 four-line shift 30");
    four_line = 0; shift_ofs = 0; cursor_on = 1; cursor_addr = 7'h19;
    run_frames(1, "R7 cursor two-line");
    four_line = 1; shift_ofs = 2; cursor_addr = 7'h63;
    run_frames(1, "R7 cursor four-line shifted");
    four_line = 0; shift_ofs = 0; cursor_on = 0; blink_on = 1; cursor_addr = 7'h45;
    run_frames(3, "R8 blink");
    cursor_on = 1;
    run_frames(2, "R8 blink over cursor");
    blink_on = 0; cursor_on = 0; disp_on = 0;
    run_frames(1, "R9 display off");
    disp_on = 1;
    run_frames(1, "R9 display back on");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule